// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small single-cycle processor for a 32-bit load/store instruction set using the classic three-format encoding. In each active cycle it takes one 32-bit word from its internal instruction memory, splits it into fields, reads two operands from a 32-entry register file and computes with an ALU. It then writes the result back, or moves a word between a register and its internal data memory. At the end of the cycle the program counter advances by four, branches or jumps.

Both memories are filled through a word-wide load port, normally while reset is held. Retired instructions can be watched on observation outputs: the register write-back, the store request and the current PC. A sticky flag records signed overflow of the trapping add forms. No exception is raised.

Top module: `mlc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `ovf_o` is 0, and `wb_en_o` and `st_en_o` are low. After `rst_n` rises, nothing executes on the first two rising clock edges. The instruction at byte address 0 is presented after the second edge and retires on the third.
- R2: Opcode 0 selects a register-register operation by funct, writing rd = rs op rt modulo 2^32. add is funct 0x20, addu is 0x21 and subu is 0x23. Fields are opcode[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: add and addi set `ovf_o` one cycle after a retired instruction whose signed result overflows, and still write their result. The flag stays set until reset. addu and subu never set it.
- R4: Under opcode 0, funct 0x24 gives and, 0x25 gives or, 0x26 gives xor and 0x27 gives nor, the inverse of rs|rt.
- R5: slt (opcode 0, funct 0x2A) writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R6: The result goes to rt. addi (0x08) adds the sign-extended imm[15:0]. andi (0x0C) and ori (0x0D) use the zero-extended immediate. lui (0x0F) writes {imm, 16'h0}.
- R7: Register 0 always reads as 0. A result aimed at register 0 is dropped, and `wb_en_o` stays low for it.
- R8: lw (0x23) and sw (0x2B) use the byte address rs + sign-extended immediate, and address bits [7:2] select one of 64 data words. lw writes the word to rt. sw shows `st_en_o` with that address and rt's value, and the word is stored at the clock edge.
- R9: beq (0x04) sets the next PC to PC+4+{14 copies of imm[15], imm, 2'b00} when rs equals rt, and to PC+4 otherwise.
- R10: j (0x02) sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R11: An unrecognised opcode, or an unrecognised funct under opcode 0, writes nothing, stores nothing and advances the PC by 4. The instruction word index is PC bits [9:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through two flops |
| load_en | input | 1 | Write `load_word` into a memory at the next edge |
| load_to_imem | input | 1 | 1 selects the instruction memory, 0 selects the data memory |
| load_idx | input | 8 | Word index for the load |
| load_word | input | 32 | Word to be loaded |
| pc_o | output | 32 | Byte address of the instruction now executing |
| wb_en_o | output | 1 | A register write happens at the next edge |
| wb_idx_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value written |
| st_en_o | output | 1 | A data-memory store happens at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word stored |
| ovf_o | output | 1 | Sticky signed-overflow flag |

## Verification
Overflow detection and the register-0 discard can happen on the same instruction. A directed `add r0, r1, r1` with r1 = 0x7FFFFFFF provokes this. It must raise `ovf_o` one cycle later while `wb_en_o` stays low, and a following `or r4, r0, r0` must write 0. Around this case, a seeded random program of every supported class, with random register fields that often include register 0, runs in lock step with a reference model in the bench. Each cycle, the bench compares the PC, the write-back and the store outputs against the model.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    imm_zext;
    logic    wr_en;
    logic    wr_rt;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    ovf_chk;
  } ctrl_t;
endpackage

// File: rtl/mlc_decode.sv
module mlc_decode
  import mlc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.wr_en = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.ovf_chk = 1'b1;
          FN_ADDU: ctrl.alu_op  = ALU_ADD;
          FN_SUBU: ctrl.alu_op  = ALU_SUB;
          FN_AND:  ctrl.alu_op  = ALU_AND;
          FN_OR:   ctrl.alu_op  = ALU_OR;
          FN_XOR:  ctrl.alu_op  = ALU_XOR;
          FN_NOR:  ctrl.alu_op  = ALU_NOR;
          FN_SLT:  ctrl.alu_op  = ALU_SLT;
          default: ctrl.wr_en   = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.wr_en = 1'b1; ctrl.wr_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.ovf_chk = 1'b1;
      end
      OP_ANDI: begin
        ctrl.wr_en = 1'b1; ctrl.wr_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
        ctrl.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctrl.wr_en = 1'b1; ctrl.wr_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
        ctrl.alu_op = ALU_OR;
      end
      OP_LUI: begin
        ctrl.wr_en = 1'b1; ctrl.wr_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_LUI;
      end
      OP_LW: begin
        ctrl.wr_en = 1'b1; ctrl.wr_rt = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1;
      end
      OP_BEQ:  ctrl.branch = 1'b1;
      OP_J:    ctrl.jump   = 1'b1;
      default: ctrl.wr_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/mlc_alu.sv
module mlc_alu
  import mlc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         add_ovf
);
  localparam int HW = W / 2;
  logic [W-1:0] sum;

  always_comb begin
    sum     = a + b;
    add_ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    unique case (op)
      ALU_ADD: y = sum;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_LUI: y = {b[HW-1:0], {HW{1'b0}}};
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/mlc_regfile.sv
module mlc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (wa == AW'(g))) regs[g] <= wd;
    end
  end

  always_comb begin
    rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  end
endmodule

// File: rtl/mlc_core.sv
module mlc_core
  import mlc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 6,
  localparam int LDW    = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            load_to_imem,
  input  logic [LDW-1:0]  load_idx,
  input  logic [31:0]     load_word,
  output logic [31:0]     pc_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [31:0]     wb_data_o,
  output logic            st_en_o,
  output logic [31:0]     st_addr_o,
  output logic [31:0]     st_data_o,
  output logic            ovf_o
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam int HALF       = XLEN / 2;

  logic [1:0] rst_sync_q;
  logic       run;
  logic [31:0] pc_q, pc_d, pc_plus4, br_off;
  logic        ovf_q, ovf_d;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y;
  logic        alu_ovf;
  logic [4:0]  dest;
  ctrl_t       ctrl;
  logic [DMEM_AW-1:0] d_idx;

  // reset release: two flops, asserted asynchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  // memories
  always_ff @(posedge clk) begin
    if (load_en && load_to_imem) imem[load_idx[IMEM_AW-1:0]] <= load_word;
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_to_imem) dmem[load_idx[DMEM_AW-1:0]] <= load_word;
    else if (st_en_o)             dmem[d_idx] <= rt_val;
  end

  assign instr = imem[pc_q[IMEM_AW+1:2]];

  mlc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  mlc_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk  (clk),
    .ra_a (instr[25:21]),
    .ra_b (instr[20:16]),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (wb_en_o),
    .wa   (dest),
    .wd   (wb_data_o)
  );

  always_comb begin
    imm_ext = ctrl.imm_zext ? {{HALF{1'b0}}, instr[15:0]}
                            : {{HALF{instr[15]}}, instr[15:0]};
    alu_b   = ctrl.use_imm ? imm_ext : rt_val;
  end

  mlc_alu #(.W(XLEN)) u_alu (
    .a       (rs_val),
    .b       (alu_b),
    .op      (ctrl.alu_op),
    .y       (alu_y),
    .add_ovf (alu_ovf)
  );

  // write-back and store
  always_comb begin
    d_idx     = alu_y[DMEM_AW+1:2];
    dest      = ctrl.wr_rt ? instr[20:16] : instr[15:11];
    wb_en_o   = run && ctrl.wr_en && (dest != 5'd0);
    wb_idx_o  = dest;
    wb_data_o = ctrl.mem_rd ? dmem[d_idx] : alu_y;
    st_en_o   = run && ctrl.mem_wr;
    st_addr_o = alu_y;
    st_data_o = rt_val;
  end

  // next state
  always_comb begin
    pc_plus4 = pc_q + 32'd4;
    br_off   = {{14{instr[15]}}, instr[15:0], 2'b00};
    if (ctrl.jump)                            pc_d = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (ctrl.branch && rs_val == rt_val) pc_d = pc_plus4 + br_off;
    else                                      pc_d = pc_plus4;
    ovf_d = ovf_q | (ctrl.ovf_chk & alu_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
    end else if (run) begin
      pc_q  <= pc_d;
      ovf_q <= ovf_d;
    end
  end

  assign pc_o  = pc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mlc_core_chk.sv
module mlc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic        wb_en_o,
  input logic [4:0]  wb_idx_o,
  input logic        st_en_o,
  input logic        ovf_o
);
  // R7: register 0 is never the target of a reported write
  a_r7_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_idx_o != 5'd0));

  // R3: overflow flag is sticky
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R8: a store never writes a register and always continues sequentially
  a_r8_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_o |-> !wb_en_o);
  a_r8_store_seq: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_o |=> (pc_o == $past(pc_o) + 32'd4));

  // R11: PC stays word aligned
  a_r11_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  // R1: quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!wb_en_o && !st_en_o && !ovf_o && pc_o == 32'd0);
    end
  end
endmodule

bind mlc_core mlc_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_o     (pc_o),
  .wb_en_o  (wb_en_o),
  .wb_idx_o (wb_idx_o),
  .st_en_o  (st_en_o),
  .ovf_o    (ovf_o)
);

// File: tb/test_mlc_core.sv
module test_mlc_core;
  localparam int CLK_PERIOD = 10;
  localparam int NRUN       = 1500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en, load_to_imem;
  logic [7:0]  load_idx;
  logic [31:0] load_word;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_en_o, st_en_o, ovf_o;
  logic [4:0]  wb_idx_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_imem [256];
  logic [31:0] m_dmem [64];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;
  logic        m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlc_core i_mlc_core (
    .clk, .rst_n, .load_en, .load_to_imem, .load_idx, .load_word,
    .pc_o, .wb_en_o, .wb_idx_o, .wb_data_o, .st_en_o, .st_addr_o, .st_data_o, .ovf_o
  );

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] t);
    return {6'h02, t};
  endfunction

  function automatic logic [31:0] rget(logic [4:0] r);
    return (r == 5'd0) ? 32'd0 : m_reg[r];
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [4:0]  a = 5'($urandom % 32);
    logic [4:0]  b = 5'($urandom % 32);
    logic [4:0]  c = 5'($urandom % 32);
    logic [15:0] im = 16'($urandom);
    int k = int'($urandom % 18);
    case (k)
      0:  return enc_r(6'h20, c, a, b);
      1:  return enc_r(6'h21, c, a, b);
      2:  return enc_r(6'h23, c, a, b);
      3:  return enc_r(6'h24, c, a, b);
      4:  return enc_r(6'h25, c, a, b);
      5:  return enc_r(6'h26, c, a, b);
      6:  return enc_r(6'h27, c, a, b);
      7:  return enc_r(6'h2A, c, a, b);
      8:  return enc_i(6'h08, b, a, im);
      9:  return enc_i(6'h0C, b, a, im);
      10: return enc_i(6'h0D, b, a, im);
      11: return enc_i(6'h0F, b, a, im);
      12: return enc_i(6'h23, b, a, im);
      13: return enc_i(6'h2B, b, a, im);
      14: return enc_i(6'h04, b, (($urandom % 2) == 0) ? b : a, 16'($signed(int'($urandom % 9) - 4)));
      15: return enc_j(26'(62 + ($urandom % 194)));
      16: return {6'h3F, 26'($urandom)};
      default: return enc_r(6'h00, c, a, b);
    endcase
  endfunction

  // expected outcome of the instruction at m_pc, then commit to the model
  task automatic step_and_check();
    logic [31:0] ins = m_imem[m_pc[9:2]];
    logic [5:0]  op = ins[31:26], fn = ins[5:0];
    logic [4:0]  rs = ins[25:21], rt = ins[20:16], rd = ins[15:11];
    logic [31:0] a = rget(rs), b = rget(rt);
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx = {16'h0, ins[15:0]};
    logic [31:0] y = 32'd0, npc = m_pc + 32'd4, sa = 32'd0, sd = 32'd0;
    logic        wr = 1'b0, st = 1'b0, ov = 1'b0;
    logic [4:0]  dst = rd;
    logic        e_wb;
    string       tag = "R11";
    case (op)
      6'h00: begin
        wr = 1'b1;
        case (fn)
          6'h20: begin y = a + b; ov = (a[31] == b[31]) && (y[31] != a[31]); tag = "R2"; end
          6'h21: begin y = a + b; tag = "R2"; end
          6'h23: begin y = a - b; tag = "R2"; end
          6'h24: begin y = a & b; tag = "R4"; end
          6'h25: begin y = a | b; tag = "R4"; end
          6'h26: begin y = a ^ b; tag = "R4"; end
          6'h27: begin y = ~(a | b); tag = "R4"; end
          6'h2A: begin y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5"; end
          default: wr = 1'b0;
        endcase
      end
      6'h08: begin wr = 1; dst = rt; y = a + sx; ov = (a[31] == sx[31]) && (y[31] != a[31]); tag = "R6"; end
      6'h0C: begin wr = 1; dst = rt; y = a & zx; tag = "R6"; end
      6'h0D: begin wr = 1; dst = rt; y = a | zx; tag = "R6"; end
      6'h0F: begin wr = 1; dst = rt; y = {ins[15:0], 16'h0}; tag = "R6"; end
      6'h23: begin wr = 1; dst = rt; sa = a + sx; y = m_dmem[sa[7:2]]; tag = "R8"; end
      6'h2B: begin st = 1; sa = a + sx; sd = b; tag = "R8"; end
      6'h04: begin tag = "R9"; if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h02: begin tag = "R10"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (ov) tag = "R3";
    if (wr && dst == 5'd0) tag = "R7";
    e_wb = wr && (dst != 5'd0);

    checks++;
    if (pc_o !== m_pc || wb_en_o !== e_wb || (e_wb && (wb_idx_o !== dst || wb_data_o !== y))
        || st_en_o !== st || (st && (st_addr_o !== sa || st_data_o !== sd))) begin
      errors++;
      $display("FAIL %s ins=%h: pc=%h wb=%b/%0d/%h st=%b/%h/%h expected pc=%h wb=%b/%0d/%h st=%b/%h/%h",
               tag, ins, pc_o, wb_en_o, wb_idx_o, wb_data_o, st_en_o, st_addr_o, st_data_o,
               m_pc, e_wb, dst, y, st, sa, sd);
    end
    checks++;
    if (ovf_o !== m_ovf) begin
      errors++;
      $display("FAIL R3 ovf: actual=%b expected=%b at pc=%h", ovf_o, m_ovf, m_pc);
    end

    if (e_wb) m_reg[dst] = y;
    if (st)   m_dmem[sa[7:2]] = sd;
    m_ovf = m_ovf | ov;
    m_pc  = npc;
  endtask

  task automatic check_idle(string what);
    checks++;
    if (pc_o !== 32'd0 || wb_en_o !== 1'b0 || st_en_o !== 1'b0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s: pc=%h wb=%b st=%b ovf=%b expected pc=0 wb=0 st=0 ovf=0",
               what, pc_o, wb_en_o, st_en_o, ovf_o);
    end
  endtask

  initial begin
    int w;
    void'($urandom(32'h1DEA5));
    rst_n = 1'b0; load_en = 1'b0; load_to_imem = 1'b0; load_idx = '0; load_word = '0;

    // program: register initialisation, directed corners, random tail
    w = 0;
    for (int r = 1; r < 32; r++) begin
      m_imem[w] = enc_i(6'h0F, 5'(r), 5'd0, 16'($urandom)); w++;
      m_imem[w] = enc_i(6'h0D, 5'(r), 5'(r), 16'($urandom)); w++;
    end
    m_imem[62] = enc_i(6'h0F, 5'd1, 5'd0, 16'h7FFF);
    m_imem[63] = enc_i(6'h0D, 5'd1, 5'd1, 16'hFFFF);
    m_imem[64] = enc_r(6'h21, 5'd3, 5'd1, 5'd1);          // R3: addu, no flag
    m_imem[65] = enc_r(6'h20, 5'd0, 5'd1, 5'd1);          // R3+R7: overflow into r0
    m_imem[66] = enc_r(6'h25, 5'd4, 5'd0, 5'd0);          // R7: r0 reads 0
    m_imem[67] = enc_i(6'h08, 5'd5, 5'd0, 16'hFFFC);      // R6: sign extension
    m_imem[68] = enc_i(6'h0C, 5'd6, 5'd5, 16'h8001);      // R6: zero extension
    m_imem[69] = enc_r(6'h2A, 5'd7, 5'd5, 5'd0);          // R5: -4 < 0
    m_imem[70] = enc_i(6'h04, 5'd0, 5'd0, 16'h0001);      // R9: taken
    m_imem[71] = enc_i(6'h08, 5'd8, 5'd0, 16'h0001);      // skipped
    m_imem[72] = enc_j(26'd74);                           // R10
    m_imem[73] = enc_i(6'h08, 5'd8, 5'd0, 16'h0002);      // skipped
    m_imem[74] = 32'hFC00_0000;                           // R11: unknown opcode
    m_imem[75] = enc_r(6'h3F, 5'd9, 5'd1, 5'd1);          // R11: unknown funct
    for (int i = 76; i < 256; i++) m_imem[i] = rand_instr();
    for (int i = 0; i < 64; i++)   m_dmem[i] = $urandom;
    for (int i = 0; i < 32; i++)   m_reg[i]  = 32'd0;
    m_pc = 32'd0; m_ovf = 1'b0;

    // preload while reset is held
    @(negedge clk);
    check_idle("reset asserted");
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_to_imem = 1'b1; load_idx = 8'(i); load_word = m_imem[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_to_imem = 1'b0; load_idx = 8'(i); load_word = m_dmem[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    check_idle("reset held after loading");

    rst_n = 1'b1;
    @(negedge clk);
    check_idle("first edge after release");
    @(negedge clk);
    for (int n = 0; n < NRUN; n++) begin
      step_and_check();
      @(negedge clk);
    end
    checks++;
    if (ovf_o !== 1'b1) begin
      errors++;
      $display("FAIL R3 final flag: actual=%b expected=1", ovf_o);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule